// File: doc/BRIEF.md
# Latched-input parallel-to-serial shifter

This block turns a parallel word into a serial bit stream through two storage stages. A holding register captures the parallel input word when its capture enable is high. Separately, a shift register either copies the held word in one step or moves its contents one place toward the serial output, taking a new bit from the serial input. Because the holding register has its own enable, the next word can be captured while the current one is still being shifted out.

The two clocks of a discrete part become two enables in this block, both sampled on one system clock. The shift register has an active-low asynchronous reset. That reset leaves the holding register alone, so a word captured before reset can still be loaded after it. The serial output is the last shift-register stage. The word leaves most significant bit first.

The ports are plain control and data pins with no valid/ready handshake. A word is offered by holding it on the parallel input during a capture cycle. Each shift cycle consumes exactly one serial input bit. There is no back-pressure: the user paces the stream with the two enables.

Top module: `latched_p2s_shifter`

## Requirements
- R1: On a rising `clk` edge with `cap_en` high, the holding register takes `par_in`. With `cap_en` low it keeps its value. The held word is observed through a later parallel load.
- R2: On a rising `clk` edge with `sh_en` high and `mode_sel` = 0 (load), every shift-register stage takes the holding register's value, not the `par_in` pins.
- R3: On a rising `clk` edge with `sh_en` high and `mode_sel` = 1 (shift), stage i takes stage i-1 for i = 1..WIDTH-1, and stage 0 takes `ser_in`.
- R4: `ser_out` always equals stage WIDTH-1. After a load it shows held bit WIDTH-1, and further shifts present held bits WIDTH-2 down to 0 in that order.
- R5: With `sh_en` low, the shift register and `ser_out` keep their values whatever `mode_sel`, `ser_in` or `cap_en` do.
- R6: While `rst_n` is low, the shift register is cleared without waiting for a clock and `ser_out` is 0. The holding register keeps the word it held before reset.
- R7: When a capture and a load happen on the same edge, the shift register receives the word held before that edge. The newly captured word is what the next load copies.
- R8: Bits entered on `ser_in` appear on `ser_out` WIDTH shift cycles later, in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of the shift register |
| cap_en | input | 1 | Capture enable for the holding register |
| par_in | input | WIDTH | Parallel data word |
| sh_en | input | 1 | Shift-register enable (load or shift) |
| mode_sel | input | 1 | 0 = parallel load from holding register, 1 = serial shift |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Last shift-register stage |

## Verification
On every cycle the assertions check the next-state rules of both stages: capture versus hold in the holding register (R1), load from the held word, shift with serial entry, and freeze when the shift enable is low (R2, R3, R5), and a clear shift register on reset release (R6). Other properties appear only as sequences at the serial output, and only the bench scenarios can show them. These are most-significant-first bit order, a word captured during shifting that waits for the next load, the same-edge capture-and-load ordering, a held word that survives reset, and serial fill emerging after exactly WIDTH shifts.

// File: rtl/p2s_pkg.sv
package p2s_pkg;

  // Shift-register operating mode, value as seen on the mode_sel pin.
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } sr_mode_e;

endpackage

// File: rtl/p2s_in_latch.sv
module p2s_in_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // Holding stage has no reset: it must survive a shift-register clear.
  always_ff @(posedge clk) begin
    if (cap_en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/p2s_shift_stage.sv
module p2s_shift_stage
  import p2s_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  sr_mode_e         mode,
  input  logic [WIDTH-1:0] par_d,
  input  logic             ser_d,
  output logic [WIDTH-1:0] q
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] nxt;

  // Stage 0 is fed from the serial pin, stage i from stage i-1.
  assign shifted = {q[MSB-1:0], ser_d};

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign nxt[i] = (mode == MODE_LOAD) ? par_d[i] : shifted[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (tick) begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/latched_p2s_shifter.sv
module latched_p2s_shifter
  import p2s_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] par_in,
  input  logic             sh_en,
  input  logic             mode_sel,
  input  logic             ser_in,
  output logic             ser_out
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] sr_q;
  sr_mode_e         mode;

  assign mode = sr_mode_e'(mode_sel);

  p2s_in_latch #(.WIDTH(WIDTH)) u_hold (
    .clk    (clk),
    .cap_en (cap_en),
    .d      (par_in),
    .q      (hold_q)
  );

  p2s_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (sh_en),
    .mode  (mode),
    .par_d (hold_q),
    .ser_d (ser_in),
    .q     (sr_q)
  );

  assign ser_out = sr_q[MSB];

endmodule

// File: rtl/p2s_chk.sv
module p2s_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_en,
  input logic [WIDTH-1:0] par_in,
  input logic             sh_en,
  input logic             mode_sel,
  input logic             ser_in,
  input logic             ser_out,
  input logic [WIDTH-1:0] hold,
  input logic [WIDTH-1:0] sr
);

  // R1
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> hold == $past(par_in));

  // R1
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(hold));

  // R2
  par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_en && !mode_sel) |=> sr == $past(hold));

  // R3
  ser_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_en && mode_sel) |=> sr == {$past(sr[WIDTH-2:0]), $past(ser_in)});

  // R5
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_en |=> ($stable(sr) && $stable(ser_out)));

  // R6
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sr == '0 && !ser_out));

endmodule

bind latched_p2s_shifter p2s_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cap_en   (cap_en),
  .par_in   (par_in),
  .sh_en    (sh_en),
  .mode_sel (mode_sel),
  .ser_in   (ser_in),
  .ser_out  (ser_out),
  .hold     (hold_q),
  .sr       (sr_q)
);

// File: tb/latched_p2s_shifter_tb_top.sv
module latched_p2s_shifter_tb_top;

  localparam int W          = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         cap_en = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         sh_en = 1'b0;
  logic         mode_sel = 1'b1;
  logic         ser_in = 1'b0;
  logic         ser_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference: held word plus a queue of stages, front = last stage.
  logic [W-1:0] m_hold;
  bit           m_sr[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  latched_p2s_shifter #(.WIDTH(W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .par_in   (par_in),
    .sh_en    (sh_en),
    .mode_sel (mode_sel),
    .ser_in   (ser_in),
    .ser_out  (ser_out)
  );

  task automatic check(input string tag);
    n_vec++;
    if (ser_out !== m_sr[0]) begin
      n_bad++;
      $display("FAIL %s: ser_out=%0b expected %0b at %0t", tag, ser_out, m_sr[0], $time);
    end
  endtask

  // One system clock: inputs applied after a falling edge, model updated
  // with the pre-edge held word, output compared at the next falling edge.
  task automatic step(input bit ce, input logic [W-1:0] d, input bit se,
                      input bit md, input bit si, input string tag);
    logic [W-1:0] old_hold;
    cap_en = ce; par_in = d; sh_en = se; mode_sel = md; ser_in = si;
    @(posedge clk);
    old_hold = m_hold;
    if (ce) m_hold = d;
    if (se) begin
      if (!md) begin
        m_sr = {};
        for (int i = W-1; i >= 0; i--) m_sr.push_back(old_hold[i]);
      end else begin
        void'(m_sr.pop_front());
        m_sr.push_back(si);
      end
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic clear_model();
    m_sr = {};
    for (int i = 0; i < W; i++) m_sr.push_back(1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_bad++;
    $display("FAIL watchdog: finished=0 expected 1");
    finish_run();
  end

  initial begin
    clear_model();
    m_hold = '0;
    #1 rst_n = 1'b0;
    @(negedge clk);
    check("R6 reset output low");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: capture a word; R5: shift register untouched
    step(1, 8'hA5, 0, 0, 1, "R1 R5 capture only");
    // R1: pins change without capture
    step(0, 8'h00, 0, 1, 0, "R1 no capture");
    // R2/R4: load shows held MSB first
    step(0, 8'hFF, 1, 0, 0, "R2 load from holding");
    // R4 + R7: capture 3C while shifting A5 out
    for (int i = 0; i < 3; i++) step(0, 8'h00, 1, 1, 0, "R4 msb-first order");
    step(1, 8'h3C, 1, 1, 0, "R7 capture during shift");
    for (int i = 0; i < 4; i++) step(0, 8'h00, 1, 1, 0, "R4 msb-first order");
    // R7: capture and load on the same edge
    step(1, 8'h0F, 1, 0, 0, "R7 same-edge capture and load");
    for (int i = 0; i < W; i++) step(0, 8'h00, 1, 1, 1, "R4 drain old word");
    step(0, 8'h00, 1, 0, 0, "R7 next load gets new word");
    // R8: serial fill pattern emerges after W shifts
    for (int i = 0; i < W; i++) step(0, 8'h00, 1, 1, (8'b10110010 >> i) & 1, "R3 serial entry");
    for (int i = 0; i < W; i++) step(0, 8'h00, 1, 1, 0, "R8 serial fill out");
    // R5: disabled shift register ignores mode, serial and capture
    step(1, 8'h81, 1, 0, 0, "R2 load 0F");
    for (int i = 0; i < 6; i++) step(i[0], 8'h5A, 0, i[1], i[0], "R5 frozen");
    // R6: reset mid-word, held word survives
    step(1, 8'hC3, 1, 1, 1, "R3 shift before reset");
    @(negedge clk);
    rst_n = 1'b0;
    clear_model();
    #1 check("R6 async clear");
    @(negedge clk);
    check("R6 held in reset");
    rst_n = 1'b1;
    step(0, 8'h00, 1, 0, 0, "R6 held word kept after reset");
    for (int i = 0; i < W-1; i++) step(0, 8'h00, 1, 1, 0, "R6 held word bits");
    // Mixed traffic
    for (int i = 0; i < 300; i++)
      step((i % 5) == 0, 8'(i * 37 + 11), (i % 7) != 3, (i % 9) != 0, i[2] ^ i[0],
           "R3 mixed traffic");
    finish_run();
  end

endmodule